// File: doc/BRIEF.md
# TDM Frame Serializer

This block turns a stream of parallel bytes into one serial time-division-multiplexed line. A frame is 256 bit times long and is divided into 32 slots of 8 bits. The block asks upstream logic for one byte per slot and sends each byte out one bit per clock, most significant bit first. It also raises a frame marker for exactly one bit time at the first bit of every frame. At a 2.048 MHz bit clock this gives 8000 frames per second, or one frame every 125 µs. Clock, serial data and the frame marker are the three signals that carry the line.

A request strobe, together with the index of the slot about to begin, tells the upstream source which byte to present. The source keeps that byte on `slot_byte` until the next rising edge, where the block captures it. `slot_byte` is ignored at every other edge. A synchronous reset returns the position counters to the point just before the first bit of a frame. The first frame then starts on the first clock edge after reset is released.

Top module: `tdm_frame_serializer`

## Requirements
- R1: The frame is SLOTS*BITS bit times long (256 by default). After reset is released, `frame_mark` is high for exactly one clock in every 256, and the distance from one mark to the next is always 256 clocks.
- R2: `frame_mark` is high during the first bit time of slot 0. The first mark after reset appears in the cycle that follows the first rising edge at which `rst` is sampled low.
- R3: `fetch_strobe` is high for one clock during the last bit time of each slot. It is also high in the reset state. `slot_byte` is captured at the rising edge that ends a strobe cycle.
- R4: While `fetch_strobe` is high, `fetch_slot` gives the index of the slot that begins at the next edge. It is 0 in the reset state and goes up by one at each strobe, wrapping from 31 to 0.
- R5: Bits go out most significant bit first. In bit time j of a slot (j = 0..7), `ser_data` carries bit 7-j of the byte captured for that slot.
- R6: A change of `slot_byte` in a cycle where `fetch_strobe` is low has no effect on `ser_data`.
- R7: After any rising edge at which `rst` is high: `ser_data` = 0, `frame_mark` = 0, `fetch_strobe` = 1 and `fetch_slot` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| slot_byte | input | 8 | Byte for the slot named by `fetch_slot`, sampled at the edge that ends a strobe cycle |
| fetch_strobe | output | 1 | High in the last bit time of a slot (and in the reset state): present the next byte now |
| fetch_slot | output | 5 | Index of the slot whose byte is being requested |
| ser_data | output | 1 | Serial line data, most significant bit first |
| frame_mark | output | 1 | One-bit-time frame marker on the first bit of slot 0 |

## Verification
The assertions assume that the upstream source keeps `slot_byte` at a settled value across each edge that ends a strobe cycle. They assume nothing about `slot_byte` in the other cycles. The stimulus changes inputs only on the falling edge. It drives the requested byte (directed patterns in the first frame, seeded random bytes after that) in every strobe cycle, and drives unrelated random values in all other cycles. Reset is driven high from time zero and is raised once more in the middle of a frame. This tests the assumption that the block may be restarted at any position.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

  // Number of bit times in one frame
  function automatic int unsigned frame_len(input int unsigned slots, input int unsigned bits);
    return slots * bits;
  endfunction

  // Successor of a counter that wraps at limit-1
  function automatic int unsigned wrap_inc(input int unsigned value, input int unsigned limit);
    return (value == limit - 1) ? 0 : value + 1;
  endfunction

  // Which bit of a slot byte goes out in bit time j (most significant first)
  function automatic int unsigned tx_bit_index(input int unsigned j, input int unsigned bits);
    return bits - 1 - j;
  endfunction

endpackage

// File: rtl/frame_position_counter.sv
module frame_position_counter #(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(BITS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [BW-1:0] bit_idx,
  output logic [SW-1:0] slot_idx,
  output logic          running,
  output logic          slot_last,
  output logic [SW-1:0] upcoming_slot
);
  import tdm_ser_pkg::*;

  logic [BW-1:0] bit_q;
  logic [SW-1:0] slot_q;
  logic          run_q;

  // Reset parks the position on the last bit of the last slot, so the
  // first edge after release moves to position 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q  <= BW'(BITS - 1);
      slot_q <= SW'(SLOTS - 1);
      run_q  <= 1'b0;
    end else begin
      run_q <= 1'b1;
      bit_q <= BW'(wrap_inc(int'(bit_q), BITS));
      if (bit_q == BW'(BITS - 1))
        slot_q <= SW'(wrap_inc(int'(slot_q), SLOTS));
    end
  end

  assign bit_idx       = bit_q;
  assign slot_idx      = slot_q;
  assign running       = run_q;
  assign slot_last     = (bit_q == BW'(BITS - 1));
  assign upcoming_slot = SW'(wrap_inc(int'(slot_q), SLOTS));
endmodule

// File: rtl/slot_shifter.sv
module slot_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            enable,
  input  logic [BITS-1:0] din,
  output logic            ser_bit
);
  logic [BITS-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst)
      shreg_q <= '0;
    else if (load)
      shreg_q <= din;
    else
      shreg_q <= {shreg_q[BITS-2:0], 1'b0};
  end

  assign ser_bit = enable & shreg_q[BITS-1];
endmodule

// File: rtl/frame_marker.sv
module frame_marker #(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(BITS)
) (
  input  logic          running,
  input  logic [SW-1:0] slot_idx,
  input  logic [BW-1:0] bit_idx,
  output logic          mark
);
  assign mark = running && (slot_idx == '0) && (bit_idx == '0);
endmodule

// File: rtl/tdm_frame_serializer.sv
module tdm_frame_serializer #(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BITS-1:0] slot_byte,
  output logic            fetch_strobe,
  output logic [SW-1:0]   fetch_slot,
  output logic            ser_data,
  output logic            frame_mark
);
  // Named internal events
  logic [BW-1:0] pos_bit;
  logic [SW-1:0] pos_slot;
  logic          line_active;
  logic          slot_ending;
  logic [SW-1:0] next_slot;

  frame_position_counter #(.SLOTS(SLOTS), .BITS(BITS)) u_pos (
    .clk           (clk),
    .rst           (rst),
    .bit_idx       (pos_bit),
    .slot_idx      (pos_slot),
    .running       (line_active),
    .slot_last     (slot_ending),
    .upcoming_slot (next_slot)
  );

  slot_shifter #(.BITS(BITS)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (slot_ending),
    .enable  (line_active),
    .din     (slot_byte),
    .ser_bit (ser_data)
  );

  frame_marker #(.SLOTS(SLOTS), .BITS(BITS)) u_mark (
    .running  (line_active),
    .slot_idx (pos_slot),
    .bit_idx  (pos_bit),
    .mark     (frame_mark)
  );

  assign fetch_strobe = slot_ending;
  assign fetch_slot   = next_slot;
endmodule

// File: rtl/tdm_frame_serializer_checker.sv
module tdm_frame_serializer_checker #(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(BITS),
  localparam int FRAME = SLOTS * BITS,
  localparam int CW = $clog2(FRAME) + 1
) (
  input logic            clk,
  input logic            rst,
  input logic [BITS-1:0] slot_byte,
  input logic            fetch_strobe,
  input logic [SW-1:0]   fetch_slot,
  input logic            ser_data,
  input logic            frame_mark
);
  // Distance since last frame marker
  logic          seen_q;
  logic [CW-1:0] gap_q;
  // Independent copy of the captured byte and its bit position
  logic [BITS-1:0] cap_q;
  logic [BW-1:0]   idx_q;
  logic            cap_ok_q;
  // Last requested slot
  logic [SW-1:0] last_slot_q;
  logic          have_slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0; gap_q <= '0;
      cap_q <= '0; idx_q <= '0; cap_ok_q <= 1'b0;
      last_slot_q <= '0; have_slot_q <= 1'b0;
    end else begin
      if (frame_mark) begin
        seen_q <= 1'b1; gap_q <= '0;
      end else if (gap_q != CW'(FRAME)) begin
        gap_q <= gap_q + 1'b1;
      end
      if (fetch_strobe) begin
        cap_q <= slot_byte; idx_q <= '0; cap_ok_q <= 1'b1;
        last_slot_q <= fetch_slot; have_slot_q <= 1'b1;
      end else if (cap_ok_q) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assert_mark_period_R1: assert property (@(posedge clk) disable iff (rst)
    (seen_q && gap_q == CW'(FRAME - 1)) |-> frame_mark);
  assert_mark_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    (frame_mark && seen_q) |-> gap_q == CW'(FRAME - 1));
  assert_mark_single_R1: assert property (@(posedge clk) disable iff (rst)
    frame_mark |=> !frame_mark);
  assert_mark_after_slot0_R2: assert property (@(posedge clk) disable iff (rst)
    (fetch_strobe && fetch_slot == '0) |=> frame_mark);
  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
    fetch_strobe |=> !fetch_strobe);
  assert_first_request_R4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fetch_strobe && fetch_slot == '0));
  assert_slot_step_R4: assert property (@(posedge clk) disable iff (rst)
    (fetch_strobe && have_slot_q) |->
      fetch_slot == ((last_slot_q == SW'(SLOTS - 1)) ? '0 : last_slot_q + 1'b1));
  assert_msb_first_R5: assert property (@(posedge clk) disable iff (rst)
    cap_ok_q |-> ser_data == cap_q[BITS - 1 - int'(idx_q)]);
  assert_reset_state_R7: assert property (@(posedge clk)
    rst |=> (!frame_mark && !ser_data && fetch_strobe && fetch_slot == '0));
endmodule

bind tdm_frame_serializer tdm_frame_serializer_checker #(.SLOTS(SLOTS), .BITS(BITS)) u_checker (
  .clk          (clk),
  .rst          (rst),
  .slot_byte    (slot_byte),
  .fetch_strobe (fetch_strobe),
  .fetch_slot   (fetch_slot),
  .ser_data     (ser_data),
  .frame_mark   (frame_mark)
);

// File: tb/tdm_frame_serializer_test.sv
module tdm_frame_serializer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 32;
  localparam int BITS  = 8;
  localparam int FRAME = SLOTS * BITS;
  localparam int NBYTES = 128;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] slot_byte = 8'h00;
  logic       fetch_strobe;
  logic [4:0] fetch_slot;
  logic       ser_data;
  logic       frame_mark;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] bytes [NBYTES];

  tdm_frame_serializer #(.SLOTS(SLOTS), .BITS(BITS)) uut (
    .clk(clk), .rst(rst), .slot_byte(slot_byte),
    .fetch_strobe(fetch_strobe), .fetch_slot(fetch_slot),
    .ser_data(ser_data), .frame_mark(frame_mark)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Expected-value functions derived from the requirements
  function automatic bit exp_strobe(input int k);
    return (k % BITS) == 0;
  endfunction
  function automatic int exp_slot(input int k);
    return (k / BITS) % SLOTS;
  endfunction
  function automatic bit exp_mark(input int k);
    return (k >= 1) && (((k - 1) % FRAME) == 0);
  endfunction
  function automatic bit exp_ser(input int k);
    if (k == 0) return 1'b0;
    return bytes[(k - 1) / BITS][BITS - 1 - ((k - 1) % BITS)];
  endfunction

  task automatic check(input string req, input int got, input int exp, input int k);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s k=%0d actual=%0d expected=%0d", req, k, got, exp);
    end
  endtask

  task automatic fill_bytes(input bit directed);
    for (int i = 0; i < NBYTES; i++) bytes[i] = 8'($urandom);
    if (directed) begin
      bytes[0] = 8'h80; bytes[1] = 8'h01; bytes[2] = 8'hFF;
      bytes[3] = 8'h00; bytes[4] = 8'hA5; bytes[31] = 8'h5A;
    end
  endtask

  // State k = number of edges since the release of reset
  task automatic run_frames(input int nf);
    for (int k = 0; k <= nf * FRAME; k++) begin
      check("R3 strobe", int'(fetch_strobe), int'(exp_strobe(k)), k);
      if (exp_strobe(k)) check("R4 slot", int'(fetch_slot), exp_slot(k), k);
      check("R1/R2 mark", int'(frame_mark), int'(exp_mark(k)), k);
      check("R5/R6 serial", int'(ser_data), int'(exp_ser(k)), k);
      if (exp_strobe(k)) slot_byte = bytes[k / BITS];
      else slot_byte = 8'($urandom); // R6: not sampled in this cycle
      @(negedge clk);
    end
  endtask

  task automatic check_reset_state(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      slot_byte = 8'($urandom);
      @(negedge clk);
      check("R7 ser", int'(ser_data), 0, i);
      check("R7 mark", int'(frame_mark), 0, i);
      check("R7 strobe", int'(fetch_strobe), 1, i);
      check("R7 slot", int'(fetch_slot), 0, i);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    fill_bytes(1'b1);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state(4);
    rst = 1'b0;
    run_frames(3);
    // Reset in the middle of a frame, then restart
    for (int i = 0; i < 37; i++) @(negedge clk);
    rst = 1'b1;
    check_reset_state(3);
    fill_bytes(1'b0);
    rst = 1'b0;
    run_frames(1);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule